// File: doc/BRIEF.md
# Digital I/O Register File with Change-of-State Interrupt

This block is the register file of a 56-line digital I/O function. Twenty-four lines are output latches and are never inputs. Twenty-four isolated lines are inputs and are never outputs. Eight TTL lines can be either; a direction bit in the control byte sets which. Every input line passes through a synchronizer and then an edge detector. Each 8-line bank has its own enable for rising edges and its own enable for falling edges. A detected edge sets a sticky status bit. The interrupt output stays high while any status bit is set.

A host reaches the block through a synchronous port. Each write carries a word index, four byte-lane enables and 32 bits of data, so it can update a single byte or a whole word. Reads are combinational and return a 32-bit word selected by a word index. The sixteen byte registers map onto four words. Byte offset = 4 × word + lane, and lane 0 is bits 7:0.

Top module: `dio_regfile`

## Requirements
- R1: Offsets 0, 1 and 2 hold output latches for lines 0–23. Each latch drives `out_lines` and reads back the last byte written to it. Only bytes whose lane enable is set change.
- R2: Offsets 4, 5 and 6 return the isolated inputs after the synchronizer delay of `SYNC_STAGES` clocks. Writes to offsets 4–7 have no effect.
- R3: Bit 1 of the control byte (offset 12) drives `ttl_oe`. Offset 7 returns the TTL output latch when this bit is 1 and the synchronized TTL pins when it is 0.
- R4: Offset 3 is the TTL output latch and drives `ttl_out`. A write to it takes effect only when the TTL lines are already in output mode.
- R5: The enable byte is at offset 14. Bit n (n = 0..3) enables rising-edge detection for bank n. Bit n+4 enables falling-edge detection for bank n. Bank 3 is the TTL port. A detected edge sets the matching bit of the status byte at offset 8+n.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: A read of word 2 returns all four status bytes as one little-endian word, with bank 0 in bits 7:0. A single write to word 2 with all lanes enabled can clear all of them.
- R8: `irq` is high exactly while any status bit is set. Offset 15 reads `irq` in bit 0 and zero in bits 7:1. Offset 13 reads zero.
- R9: Any write to offset 15 is a software reset. On the next clock it clears the output latches, the control byte, the enable byte and all status bits. It overrides other lanes of the same write and any edge in the same cycle.
- R10: If an edge and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R11: After hardware reset all registers read zero, the TTL lines are inputs, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 2 | Word index of the write |
| wr_be | input | 4 | Byte-lane enables of the write |
| wr_data | input | 32 | Write data, lane 0 in bits 7:0 |
| rd_word | input | 2 | Word index of the read |
| rd_data | output | 32 | Read data, combinational |
| iso_in | input | 24 | Isolated input pins |
| ttl_in | input | 8 | TTL pins as seen at the pad |
| out_lines | output | 24 | Output latch lines |
| ttl_out | output | 8 | TTL output latch |
| ttl_oe | output | 1 | TTL output enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 instead of the default 2. This places a detected edge four clock edges after the pin change. It also separates the synchronizer depth from the single edge-history register, so a model that confuses the two is caught. The deeper chain leaves room to place a clear write exactly on the cycle in which a falling edge becomes visible. The model in the bench keeps a sample queue whose length follows the same parameter.

// File: rtl/dio_pkg.sv
`timescale 1ns/1ps
package dio_pkg;
   localparam int unsigned LANES     = 4;
   localparam int unsigned BANKS     = 4;
   localparam logic [1:0]  W_OUTS    = 2'd0;
   localparam logic [1:0]  W_INS     = 2'd1;
   localparam logic [1:0]  W_COS     = 2'd2;
   localparam logic [1:0]  W_CFG     = 2'd3;
   localparam int unsigned LANE_TTL  = 3;
   localparam int unsigned LANE_CTL  = 0;
   localparam int unsigned LANE_EN   = 2;
   localparam int unsigned LANE_RST  = 3;
   localparam int unsigned DIR_BIT   = 1;
endpackage

// File: rtl/dio_sync.sv
`timescale 1ns/1ps
module dio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES+1];

   assign chain[0] = d;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s+1] <= '0;
         else        chain[s+1] <= chain[s];
      end
   end

   assign q = chain[STAGES];
endmodule

// File: rtl/dio_cos_bank.sv
`timescale 1ns/1ps
module dio_cos_bank #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_clr,
   input  logic [WIDTH-1:0] lines,
   input  logic             rise_en,
   input  logic             fall_en,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] status
);
   logic [WIDTH-1:0] last_q;
   logic [WIDTH-1:0] evt;
   logic [WIDTH-1:0] clr_eff;

   assign evt     = (lines & ~last_q & {WIDTH{rise_en}})
                  | (~lines & last_q & {WIDTH{fall_en}});
   assign clr_eff = clr_we ? clr_mask : '0;

   // edge history follows the pins only; a software reset leaves it alone
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= '0;
      else        last_q <= lines;
   end

   // a new edge outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        status <= '0;
      else if (soft_clr) status <= '0;
      else               status <= (status & ~clr_eff) | evt;
   end
endmodule

// File: rtl/dio_rd_mux.sv
`timescale 1ns/1ps
module dio_rd_mux
   import dio_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic [1:0]          rd_word,
   input  logic [4*BYTE_W-1:0] latch_q,
   input  logic [4*BYTE_W-1:0] pins_s,
   input  logic [4*BYTE_W-1:0] cos_q,
   input  logic [BYTE_W-1:0]   ctl_q,
   input  logic [BYTE_W-1:0]   en_q,
   input  logic                irq_lvl,
   output logic [4*BYTE_W-1:0] rd_data
);
   logic [BYTE_W-1:0] ttl_view;

   assign ttl_view = ctl_q[DIR_BIT] ? latch_q[LANE_TTL*BYTE_W +: BYTE_W]
                                    : pins_s[LANE_TTL*BYTE_W +: BYTE_W];

   always_comb begin
      unique case (rd_word)
         W_OUTS:  rd_data = latch_q;
         W_INS:   rd_data = {ttl_view, pins_s[3*BYTE_W-1:0]};
         W_COS:   rd_data = cos_q;
         default: rd_data = {{(BYTE_W-1){1'b0}}, irq_lvl, en_q, {BYTE_W{1'b0}}, ctl_q};
      endcase
   end
endmodule

// File: rtl/dio_regfile.sv
`timescale 1ns/1ps
module dio_regfile
   import dio_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LINE_W      = 8,
   parameter int unsigned FIXED_BANKS = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [1:0]                    wr_word,
   input  logic [3:0]                    wr_be,
   input  logic [4*LINE_W-1:0]           wr_data,
   input  logic [1:0]                    rd_word,
   output logic [4*LINE_W-1:0]           rd_data,
   input  logic [FIXED_BANKS*LINE_W-1:0] iso_in,
   input  logic [LINE_W-1:0]             ttl_in,
   output logic [FIXED_BANKS*LINE_W-1:0] out_lines,
   output logic [LINE_W-1:0]             ttl_out,
   output logic                          ttl_oe,
   output logic                          irq
);
   localparam int unsigned DATA_W = LANES * LINE_W;
   localparam int unsigned IO_W   = FIXED_BANKS * LINE_W;
   localparam int unsigned NBYTES = LANES * 4;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dio_regfile: SYNC_STAGES must be at least 2");
   end
   if (LINE_W != 8) begin : g_bad_width
      $error("dio_regfile: registers are bytes, LINE_W must be 8");
   end
   if (FIXED_BANKS + 1 != BANKS) begin : g_bad_banks
      $error("dio_regfile: map holds three fixed banks plus the TTL bank");
   end

   logic [NBYTES-1:0] byte_we;
   logic              soft_rst;
   logic [DATA_W-1:0] latch_q;
   logic [LINE_W-1:0] ctl_q;
   logic [LINE_W-1:0] en_q;
   logic [DATA_W-1:0] pins_s;
   logic [DATA_W-1:0] cos_q;
   logic              irq_lvl;

   for (genvar w = 0; w < 4; w++) begin : g_word
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign byte_we[w*LANES+l] = wr_en && (wr_word == 2'(w)) && wr_be[l];
      end
   end

   assign soft_rst = byte_we[W_CFG*LANES + LANE_RST];

   // output latches; the TTL lane accepts data only in output mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (soft_rst) begin
         latch_q <= '0;
      end else begin
         for (int l = 0; l < FIXED_BANKS; l++) begin
            if (byte_we[W_OUTS*LANES + l]) latch_q[l*LINE_W +: LINE_W] <= wr_data[l*LINE_W +: LINE_W];
         end
         if (byte_we[W_OUTS*LANES + LANE_TTL] && ctl_q[DIR_BIT])
            latch_q[LANE_TTL*LINE_W +: LINE_W] <= wr_data[LANE_TTL*LINE_W +: LINE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         en_q  <= '0;
      end else if (soft_rst) begin
         ctl_q <= '0;
         en_q  <= '0;
      end else begin
         if (byte_we[W_CFG*LANES + LANE_CTL]) ctl_q <= wr_data[LANE_CTL*LINE_W +: LINE_W];
         if (byte_we[W_CFG*LANES + LANE_EN])  en_q  <= wr_data[LANE_EN*LINE_W +: LINE_W];
      end
   end

   dio_sync #(
      .WIDTH  (DATA_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ttl_in, iso_in}),
      .q     (pins_s)
   );

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      dio_cos_bank #(
         .WIDTH (LINE_W)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_clr (soft_rst),
         .lines    (pins_s[b*LINE_W +: LINE_W]),
         .rise_en  (en_q[b]),
         .fall_en  (en_q[b+BANKS]),
         .clr_we   (byte_we[W_COS*LANES + b]),
         .clr_mask (wr_data[b*LINE_W +: LINE_W]),
         .status   (cos_q[b*LINE_W +: LINE_W])
      );
   end

   assign irq_lvl = |cos_q;

   dio_rd_mux #(
      .BYTE_W (LINE_W)
   ) u_rd (
      .rd_word (rd_word),
      .latch_q (latch_q),
      .pins_s  (pins_s),
      .cos_q   (cos_q),
      .ctl_q   (ctl_q),
      .en_q    (en_q),
      .irq_lvl (irq_lvl),
      .rd_data (rd_data)
   );

   assign out_lines = latch_q[IO_W-1:0];
   assign ttl_out   = latch_q[LANE_TTL*LINE_W +: LINE_W];
   assign ttl_oe    = ctl_q[DIR_BIT];
   assign irq       = irq_lvl;
endmodule

// File: rtl/dio_regfile_chk.sv
`timescale 1ns/1ps
module dio_regfile_chk #(
   parameter int unsigned IO_W   = 24,
   parameter int unsigned LINE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_wr,
   input logic              ctl_wr,
   input logic              cos_wr,
   input logic              soft_wr,
   input logic [IO_W-1:0]   out_lines,
   input logic [LINE_W-1:0] ttl_out,
   input logic              ttl_oe,
   input logic              irq
);
   a_r1_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_wr && !soft_wr) |=> $stable(out_lines));

   a_r3_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(ttl_oe));

   a_r4_ttl_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (!ttl_oe && !soft_wr) |=> $stable(ttl_out));

   a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !cos_wr && !soft_wr) |=> irq);

   a_r9_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
      soft_wr |=> (out_lines == '0 && ttl_out == '0 && !ttl_oe && !irq));
endmodule

bind dio_regfile dio_regfile_chk #(
   .IO_W   (FIXED_BANKS*LINE_W),
   .LINE_W (LINE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_wr    (wr_en && wr_word == 2'd0),
   .ctl_wr    (wr_en && wr_word == 2'd3 && (wr_be[0] || wr_be[3])),
   .cos_wr    (wr_en && wr_word == 2'd2),
   .soft_wr   (wr_en && wr_word == 2'd3 && wr_be[3]),
   .out_lines (out_lines),
   .ttl_out   (ttl_out),
   .ttl_oe    (ttl_oe),
   .irq       (irq)
);

// File: tb/dio_regfile_bench.sv
`timescale 1ns/1ps
module dio_regfile_bench;
   localparam int SYNC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_word = 2'd0;
   logic [3:0]  wr_be = 4'd0;
   logic [31:0] wr_data = 32'd0;
   logic [1:0]  rd_word = 2'd0;
   logic [31:0] rd_data;
   logic [23:0] iso_in = 24'd0;
   logic [7:0]  ttl_in = 8'd0;
   logic [23:0] out_lines;
   logic [7:0]  ttl_out;
   logic        ttl_oe;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   dio_regfile #(.SYNC_STAGES(SYNC)) u_dio_regfile (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_be(wr_be),
      .wr_data(wr_data), .rd_word(rd_word), .rd_data(rd_data), .iso_in(iso_in),
      .ttl_in(ttl_in), .out_lines(out_lines), .ttl_out(ttl_out), .ttl_oe(ttl_oe), .irq(irq)
   );

   // behavioural reference: pin samples wait in a queue SYNC deep
   logic [31:0] m_out = '0, m_stat = '0, m_prev = '0;
   logic [7:0]  m_ctl = '0, m_en = '0;
   logic [31:0] pin_q[$];

   initial for (int i = 0; i < SYNC; i++) pin_q.push_back('0);

   function automatic logic [31:0] exp_rd(input logic [1:0] w);
      logic [31:0] syn;
      syn = pin_q[0];
      case (w)
         2'd0:    return m_out;
         2'd1:    return {(m_ctl[1] ? m_out[31:24] : syn[31:24]), syn[23:0]};
         2'd2:    return m_stat;
         default: return {7'd0, |m_stat, m_en, 8'd0, m_ctl};
      endcase
   endfunction

   always @(posedge clk) begin
      logic [31:0] syn, evt, clr;
      if (!rst_n) begin
         m_out = '0; m_ctl = '0; m_en = '0; m_stat = '0; m_prev = '0;
         pin_q.delete();
         for (int i = 0; i < SYNC; i++) pin_q.push_back('0);
      end else begin
         syn = pin_q[0];
         for (int b = 0; b < 4; b++) begin
            evt[b*8 +: 8] = (m_en[b]   ? ( syn[b*8 +: 8] & ~m_prev[b*8 +: 8]) : 8'h00)
                          | (m_en[b+4] ? (~syn[b*8 +: 8] &  m_prev[b*8 +: 8]) : 8'h00);
            clr[b*8 +: 8] = (wr_en && wr_word == 2'd2 && wr_be[b]) ? wr_data[b*8 +: 8] : 8'h00;
         end
         if (wr_en && wr_word == 2'd3 && wr_be[3]) begin
            m_out = '0; m_ctl = '0; m_en = '0; m_stat = '0;
         end else begin
            if (wr_en && wr_word == 2'd0) begin
               for (int l = 0; l < 3; l++) if (wr_be[l]) m_out[l*8 +: 8] = wr_data[l*8 +: 8];
               if (wr_be[3] && m_ctl[1]) m_out[31:24] = wr_data[31:24];
            end
            if (wr_en && wr_word == 2'd3) begin
               if (wr_be[0]) m_ctl = wr_data[7:0];
               if (wr_be[2]) m_en  = wr_data[23:16];
            end
            m_stat = (m_stat & ~clr) | evt;
         end
         m_prev = syn;
         void'(pin_q.pop_front());
         pin_q.push_back({ttl_in, iso_in});
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string word_tag(input logic [1:0] w);
      case (w)
         2'd0:    return "R1 word0";
         2'd1:    return "R2 word1";
         2'd2:    return "R5 word2";
         default: return "R8 word3";
      endcase
   endfunction

   // per-cycle comparison against the model
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         check(word_tag(rd_word), rd_data, exp_rd(rd_word));
         check("R1 out_lines", {8'd0, out_lines}, {8'd0, m_out[23:0]});
         check("R4 ttl_out", {24'd0, ttl_out}, {24'd0, m_out[31:24]});
         check("R3 ttl_oe", {31'd0, ttl_oe}, {31'd0, m_ctl[1]});
         check("R8 irq", {31'd0, irq}, {31'd0, |m_stat});
      end
   end

   task automatic wr(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
      wr_en = 1'b1; wr_word = w; wr_be = be; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_be = 4'd0;
   endtask

   task automatic chk_rd(input logic [1:0] w, input logic [31:0] exp, input string tag);
      rd_word = w;
      #1;
      check(tag, rd_data, exp);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      chk_rd(2'd0, 32'h0, "R11 word0");
      chk_rd(2'd2, 32'h0, "R11 word2");
      chk_rd(2'd3, 32'h0, "R11 word3");
      check("R11 ttl_oe", {31'd0, ttl_oe}, 32'd0);
      @(negedge clk);

      // R1 byte-lane writes; R4 TTL lane ignored in input mode
      wr(2'd0, 4'b0111, 32'h44A55A3C);
      wr(2'd0, 4'b0010, 32'h0000FF00);
      chk_rd(2'd0, 32'h00A5FF3C, "R1 latch readback");
      wr(2'd0, 4'b1000, 32'h77000000);
      chk_rd(2'd0, 32'h00A5FF3C, "R4 ttl write in input mode");
      check("R4 ttl_out", {24'd0, ttl_out}, 32'd0);

      // R2 inputs read-only and synchronized
      wr(2'd1, 4'b1111, 32'hFFFFFFFF);
      iso_in = 24'h123456; ttl_in = 8'h9C;
      repeat (SYNC + 1) @(negedge clk);
      chk_rd(2'd1, 32'h9C123456, "R2 input word");
      chk_rd(2'd0, 32'h00A5FF3C, "R2 write ignored");
      @(negedge clk);

      // R3 direction bit, R4 TTL latch in output mode
      wr(2'd3, 4'b0001, 32'h00000002);
      wr(2'd0, 4'b1000, 32'h5A000000);
      chk_rd(2'd1, 32'h5A123456, "R3 ttl view in output mode");
      chk_rd(2'd0, 32'h5AA5FF3C, "R1 latch with ttl");
      check("R3 ttl_oe", {31'd0, ttl_oe}, 32'd1);
      check("R4 ttl_out", {24'd0, ttl_out}, 32'h5A);
      @(negedge clk);

      // R5 per-bank rise/fall enables
      wr(2'd3, 4'b0100, 32'h00810000);
      iso_in = 24'h12FF57; ttl_in = 8'h1D;
      repeat (SYNC + 2) @(negedge clk);
      chk_rd(2'd2, 32'h80000001, "R5 status after edges");
      chk_rd(2'd3, 32'h01810002, "R8 irq readback");
      check("R8 irq high", {31'd0, irq}, 32'd1);
      @(negedge clk);

      // R6 write-one-to-clear
      wr(2'd2, 4'b0001, 32'h000000FE);
      chk_rd(2'd2, 32'h80000001, "R6 zero leaves bit");
      wr(2'd2, 4'b0001, 32'h00000001);
      chk_rd(2'd2, 32'h80000000, "R6 one clears bit");
      check("R8 irq still high", {31'd0, irq}, 32'd1);
      @(negedge clk);

      // R7 little-endian word and full clear
      wr(2'd3, 4'b0100, 32'h00870000);
      iso_in = 24'h93FF57;
      repeat (SYNC + 2) @(negedge clk);
      chk_rd(2'd2, 32'h80810000, "R7 word layout");
      wr(2'd2, 4'b1111, 32'hFFFFFFFF);
      chk_rd(2'd2, 32'h00000000, "R7 word clear");
      check("R8 irq low", {31'd0, irq}, 32'd0);
      @(negedge clk);

      // R10 edge and clear in the same cycle
      wr(2'd3, 4'b0100, 32'h00110000);
      iso_in = 24'h93FF56;
      repeat (SYNC) @(negedge clk);
      wr(2'd2, 4'b0001, 32'h00000001);
      chk_rd(2'd2, 32'h00000001, "R10 set wins");
      check("R10 irq", {31'd0, irq}, 32'd1);
      @(negedge clk);

      // R9 software reset overrides a control write in the same access
      wr(2'd3, 4'b1001, 32'hAA000003);
      chk_rd(2'd0, 32'h0, "R9 latches cleared");
      chk_rd(2'd2, 32'h0, "R9 status cleared");
      chk_rd(2'd3, 32'h0, "R9 config cleared");
      check("R9 ttl_oe", {31'd0, ttl_oe}, 32'd0);
      @(negedge clk);

      // mixed traffic against the model
      for (int c = 0; c < 600; c++) begin
         logic [3:0] be;
         be = 4'($urandom);
         wr_word = 2'($urandom);
         if (wr_word == 2'd3 && be[3] && ($urandom % 8 != 0)) be[3] = 1'b0;
         wr_en   = ($urandom % 3 == 0);
         wr_be   = be;
         wr_data = $urandom;
         rd_word = 2'($urandom);
         if ($urandom % 4 == 0) iso_in = 24'($urandom);
         if ($urandom % 4 == 0) ttl_in = 8'($urandom);
         @(negedge clk);
      end
      wr_en = 1'b0;
      @(negedge clk);
      #3;
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end
endmodule